// File: doc/BRIEF.md
# Serial-Loaded Attenuator Control Register

This block sets a six-stage step attenuator from a slow three-wire control port: a serial data line, a serial clock and a load strobe. The stages weigh 16, 8, 4, 2, 1 and 0.5 dB. Each rising edge of the serial clock moves one bit into a shift register, most significant bit first. A level-sensitive output latch sits behind that register. While the strobe is high, the step controls track the register. When the strobe goes low, they keep the last value.

All three serial lines are sampled by a fast system clock through two-flop synchronizers, so the whole block runs on one clock. While the reset input is held, both the shift register and the output latch take their value from six parallel preset pins. Any of the 64 codes can therefore be the starting setting. Beside the step controls, the block also outputs the setting as a count of half-dB units and shows the current shift register contents.

Top module: `atten_serial_ctrl`

## Requirements
- R1: While `rst` is high at a `clk` edge, the shift register and the output latch are both loaded from `preset`. After that edge, `step_ctrl` and `shift_view` equal `preset`.
- R2: The code layout is bit 5 = 16 dB, bit 4 = 8 dB, bit 3 = 4 dB, bit 2 = 2 dB, bit 1 = 1 dB and bit 0 = 0.5 dB. The first of six serial bits ends in bit 5 and the last ends in bit 0.
- R3: A low-to-high change of `ser_clk` shifts the register left by one and puts `ser_data` into bit 0. The change shows on `shift_view` after the third `clk` rising edge that follows the input change. A high-to-low change of `ser_clk` causes no shift.
- R4: Shifting happens whatever the level of `ser_le`. While `ser_le` is low, `step_ctrl` does not change when bits are shifted in.
- R5: From the second `clk` edge after `ser_le` goes high, and for as long as it stays high, `step_ctrl` equals `shift_view` in every cycle.
- R6: When the synchronized `ser_le` falls, `step_ctrl` keeps the register value from the cycle before the fall. It then stays constant until `ser_le` is high again or a reset occurs.
- R7: `atten_halfdb` always equals `step_ctrl` read as an unsigned binary number (0 to 63 half-dB units).
- R8: A reset applied in the middle of operation reloads both the register and the latch from the current `preset` value. This throws away any partly shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst | input | 1 | Synchronous active-high reset; loads from preset |
| preset | input | 6 | Parallel code loaded into register and latch during reset |
| ser_clk | input | 1 | Serial clock; data shifts on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; high makes the latch transparent |
| step_ctrl | output | 6 | Step enables, bit 5 = 16 dB down to bit 0 = 0.5 dB |
| atten_halfdb | output | 6 | Attenuation in half-dB units |
| shift_view | output | 6 | Current shift register contents |

## Verification
A corrupted shift register shows up on `shift_view` at the edge where the bad shift happens, three system clocks after the serial clock edge that caused it. With the strobe high, the same error reaches `step_ctrl` in that same cycle. A latch that captures at the wrong moment, or lets changes through while the strobe is low, shows on `step_ctrl` and `atten_halfdb` as soon as a bit is shifted in with the strobe low. The bench's reference model is compared against all three outputs on every system clock, so any such error is caught in the first cycle it becomes visible.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int CODE_W = 6;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t sh;
        logic  prev;
    } shift_st_t;

    typedef struct packed {
        code_t hold;
    } latch_st_t;
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0] chain_d [WIDTH];
    logic [STAGES-1:0] chain_q [WIDTH];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            chain_d[i] = {chain_q[i][STAGES-2:0], din[i]};
            if (rst) chain_d[i] = '0;
        end

        always_ff @(posedge clk) begin
            chain_q[i] <= chain_d[i];
        end

        assign dout[i] = chain_q[i][STAGES-1];
    end
endmodule

// File: rtl/atten_shift.sv
module atten_shift
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t preset,
    input  logic  sclk_s,
    input  logic  sdata_s,
    output code_t sh_out
);
    shift_st_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d      = st_q;
        rise      = sclk_s & ~st_q.prev;
        st_d.prev = sclk_s;
        if (rise) st_d.sh = {st_q.sh[CODE_W-2:0], sdata_s};
        if (rst) begin
            st_d.sh   = preset;
            st_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sh_out = st_q.sh;

    // R3
    no_edge_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(rise)) |-> $stable(st_q.sh));

    // R3
    edge_shift_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rise)) |->
        (st_q.sh == {$past(st_q.sh[CODE_W-2:0]), $past(sdata_s)}));
endmodule

// File: rtl/atten_latch.sv
module atten_latch
    import atten_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  code_t preset,
    input  logic  le_s,
    input  code_t sh_in,
    output code_t step_out
);
    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (le_s) st_d.hold = sh_in;
        if (rst)  st_d.hold = preset;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign step_out = le_s ? sh_in : st_q.hold;

    // R4
    hold_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !le_s && $past(!le_s)) |-> $stable(step_out));

    // R6
    capture_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(le_s) && !le_s) |-> (step_out == $past(sh_in)));
endmodule

// File: rtl/atten_serial_ctrl.sv
module atten_serial_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] preset,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [CODE_W-1:0] step_ctrl,
    output logic [CODE_W-1:0] atten_halfdb,
    output logic [CODE_W-1:0] shift_view
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] raw_in, sync_out;
    code_t              sh_val, step_val;

    assign raw_in = {ser_le, ser_data, ser_clk};

    atten_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_out)
    );

    atten_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .preset  (preset),
        .sclk_s  (sync_out[0]),
        .sdata_s (sync_out[1]),
        .sh_out  (sh_val)
    );

    atten_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .preset   (preset),
        .le_s     (sync_out[2]),
        .sh_in    (sh_val),
        .step_out (step_val)
    );

    assign step_ctrl    = step_val;
    assign atten_halfdb = step_val;
    assign shift_view   = sh_val;

    // R5
    transparent_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && sync_out[2] && $past(sync_out[2]) && $changed(shift_view))
        |-> $changed(step_ctrl));
endmodule

// File: tb/tb_atten_serial_ctrl.sv
module tb_atten_serial_ctrl;
    logic       clk = 0;
    logic       rst = 1;
    logic [5:0] preset = 6'b101101;
    logic       ser_clk = 0, ser_data = 0, ser_le = 0;
    logic [5:0] step_ctrl, atten_halfdb, shift_view;

    int compared = 0, mismatched = 0;
    bit started = 0;

    atten_serial_ctrl dut (
        .clk(clk), .rst(rst), .preset(preset),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .step_ctrl(step_ctrl), .atten_halfdb(atten_halfdb), .shift_view(shift_view)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    bit q_clk[$], q_dat[$], q_le[$];
    int m_sh, m_hold;
    bit m_prev;

    always @(posedge clk) begin
        if (rst) begin
            q_clk = '{0, 0}; q_dat = '{0, 0}; q_le = '{0, 0};
            m_sh = preset; m_hold = preset; m_prev = 0;
        end else begin
            if (q_le[0]) m_hold = m_sh;
            if (q_clk[0] && !m_prev) m_sh = ((m_sh * 2) % 64) + q_dat[0];
            m_prev = q_clk[0];
            void'(q_clk.pop_front()); q_clk.push_back(ser_clk);
            void'(q_dat.pop_front()); q_dat.push_back(ser_data);
            void'(q_le.pop_front());  q_le.push_back(ser_le);
        end
        started = 1;
    end

    function automatic int exp_step();
        return q_le[0] ? m_sh : m_hold;
    endfunction

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            check("R5/R6 model step_ctrl", step_ctrl, exp_step());
            check("R3 model shift_view", shift_view, m_sh);
            check("R7 model atten_halfdb", atten_halfdb, exp_step());
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(bit b);
        ser_data = b; cyc(2);
        ser_clk = 1;  cyc(4);
        ser_clk = 0;  cyc(4);
    endtask

    task automatic send_word(logic [5:0] w);
        for (int i = 5; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        ser_le = 1; cyc(5);
        ser_le = 0; cyc(5);
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [5:0] v;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        check("R1 step after reset", step_ctrl, 6'b101101);
        check("R1 view after reset", shift_view, 6'b101101);

        // R2 MSB first, bit5 = 16 dB
        send_word(6'b100000); pulse_le();
        check("R2 16dB bit5", step_ctrl, 6'b100000);
        send_word(6'b000001); pulse_le();
        check("R2 0.5dB bit0", step_ctrl, 6'b000001);
        check("R7 halfdb 1", atten_halfdb, 1);

        // R3 latency and falling edge no shift
        v = shift_view;
        ser_data = 1; ser_clk = 1;
        cyc(2);
        check("R3 no shift yet", shift_view, v);
        cyc(1);
        check("R3 shift at third edge", shift_view, {v[4:0], 1'b1});
        v = shift_view;
        ser_clk = 0; cyc(5);
        check("R3 fall no shift", shift_view, v);

        // R4 shifting with le low keeps outputs
        v = step_ctrl;
        send_word(6'b110011);
        check("R4 view updated le low", shift_view, 6'b110011);
        check("R4 step held le low", step_ctrl, v);

        // R5 transparent follow
        ser_le = 1; cyc(3);
        check("R5 follow after le high", step_ctrl, 6'b110011);
        send_bit(0);
        check("R5 follow shifted", step_ctrl, 6'b100110);
        check("R7 halfdb follow", atten_halfdb, 6'b100110);

        // R6 hold after fall
        ser_le = 0; cyc(3);
        send_word(6'b010101);
        check("R6 held after fall", step_ctrl, 6'b100110);
        check("R6 view moved", shift_view, 6'b010101);
        send_word(6'b111111); pulse_le();
        check("R7 halfdb max", atten_halfdb, 63);

        // R8 reset mid-word
        send_bit(0); send_bit(1);
        preset = 6'b011010;
        rst = 1; cyc(2); rst = 0; cyc(1);
        check("R8 step from preset", step_ctrl, 6'b011010);
        check("R8 view from preset", shift_view, 6'b011010);
        send_word(6'b000000); pulse_le();
        check("R7 halfdb zero", atten_halfdb, 0);

        cyc(5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule